// File: doc/BRIEF.md
# Sixteen-Bit Word Load/Store Core

This block is a compact multi-cycle execution core for a fixed-length instruction set in which every instruction is exactly one 16-bit word. It holds eight 16-bit general registers. It reaches one external, single-ported, synchronous word memory through an address, write-data, read-data and write-enable port. That memory holds both code and data. The core fetches a word, decodes it, and then either moves data between a register and memory, or halts.

Three operations exist. The first loads through an address held in a register. The second stores through an address held in a register. The third is a PC-relative literal load. No instruction word has room for a full 16-bit immediate. So a complete constant or address is placed as a data word close to the code. The literal load fetches that word with a short signed displacement from the program counter. Any other encoding stops the core, and it stays stopped until reset.

Top module: `ldst_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC and all eight registers are cleared. After such an edge, `halt` and `mem_we` are low and `mem_addr` is 0, because the first fetch uses address 0.
- R2: Instructions are fetched one word each, from consecutive addresses that start at the PC. The PC advances by exactly one per instruction and changes only in the fetch cycle.
- R3: A word with bits [15:10] = 110000 is a load. Memory is read at the address in register bits [9:7], and the word read is written into register bits [6:4].
- R4: A word with bits [15:10] = 110001 is a store. The value of register bits [9:7] is written to the address held in register bits [6:4]. For both load and store, bits [3:0] have no effect.
- R5: A word with bits [15:12] = 1110 is a literal load. Bits [11:9] name the destination register and bits [8:0] hold a two's-complement offset (-256 to +255). The core loads the word at (instruction address + 1 + sign-extended offset).
- R6: A store takes 3 clock cycles (fetch, decode, memory). A load and a literal load each take 4 cycles (fetch, decode, memory, write-back). An undefined word asserts `halt` 2 cycles after its fetch cycle begins.
- R7: Every other encoding is undefined, including 111111 and 000000. An undefined encoding asserts `halt`, which stays high until reset. While halted, `mem_we` stays low and no register changes.
- R8: All address arithmetic wraps modulo 2^16. This applies to the PC increment and to the literal address.
- R9: `mem_we` is high for exactly one cycle per store, and never high for any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address to the memory |
| mem_wdata | output | 16 | Data to write to the memory |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| mem_we | output | 1 | Write strobe for the memory |
| halt | output | 1 | High once an undefined word has been decoded |

## Verification
The assertions take two things for granted about the attached memory. It returns the word for an address on the clock edge after that address is presented. It holds a written word until it is overwritten. The bench memory model follows this exactly, and the bench drives `rst` high from time zero. The random programs place literal pointers in a pool within reach of the code, and make data words partly pointers back into a data region. Most addresses then stay inside the memory that is modelled. Stray addresses still land in the model, so every result remains comparable.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    // Instruction word geometry
    localparam int INSN_W    = 16;
    localparam int REG_IDX_W = 3;
    localparam int LIT_OFF_W = 9;

    // Two-register format: opcode in [15:10]
    localparam logic [5:0] OPC_LOAD  = 6'b110000;
    localparam logic [5:0] OPC_STORE = 6'b110001;
    // Literal format: 4-bit prefix in [15:12], dest [11:9], offset [8:0]
    localparam logic [3:0] OPC_LIT   = 4'b1110;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_MEM    = 3'd2,
        ST_WB     = 3'd3,
        ST_HALT   = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LIT   = 2'd2,
        OP_BAD   = 2'd3
    } kind_e;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [INSN_W-1:0]    instr,
    output kind_e                kind,
    output logic [REG_IDX_W-1:0] ra,
    output logic [REG_IDX_W-1:0] rb,
    output logic [REG_IDX_W-1:0] rd,
    output logic [DATA_W-1:0]    off
);

    localparam int EXT_W = DATA_W - LIT_OFF_W;

    always_comb begin
        ra   = instr[9:7];
        rb   = instr[6:4];
        rd   = instr[11:9];
        off  = {{EXT_W{instr[LIT_OFF_W-1]}}, instr[LIT_OFF_W-1:0]};
        kind = OP_BAD;
        if (instr[15:10] == OPC_LOAD) begin
            kind = OP_LOAD;
        end else if (instr[15:10] == OPC_STORE) begin
            kind = OP_STORE;
        end else if (instr[15:12] == OPC_LIT) begin
            kind = OP_LIT;
        end
    end

endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/ldst_core.sv
module ldst_core
    import ldst_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              halt
);

    localparam int NREGS = 1 << REG_IDX_W;

    typedef struct packed {
        state_e                state;
        logic [DATA_W-1:0]     pc;
        logic [DATA_W-1:0]     ea;
        logic [DATA_W-1:0]     sdata;
        logic [REG_IDX_W-1:0]  dst;
        logic                  is_store;
    } core_t;

    core_t q, d;

    kind_e                dec_kind;
    logic [REG_IDX_W-1:0] dec_ra, dec_rb, dec_rd;
    logic [DATA_W-1:0]    dec_off;
    logic [DATA_W-1:0]    rf_a, rf_b;
    logic                 rf_we;

    // The instruction word arrives on mem_rdata during the decode cycle
    ldst_decode #(.DATA_W(DATA_W)) u_dec (
        .instr (mem_rdata[INSN_W-1:0]),
        .kind  (dec_kind),
        .ra    (dec_ra),
        .rb    (dec_rb),
        .rd    (dec_rd),
        .off   (dec_off)
    );

    ldst_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (q.dst),
        .wdata   (mem_rdata),
        .raddr_a (dec_ra),
        .rdata_a (rf_a),
        .raddr_b (dec_rb),
        .rdata_b (rf_b)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_wdata = q.sdata;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        case (q.state)
            ST_FETCH: begin
                d.pc    = q.pc + 1'b1;
                d.state = ST_DECODE;
            end
            ST_DECODE: begin
                case (dec_kind)
                    OP_LOAD: begin
                        d.ea       = rf_a;
                        d.dst      = dec_rb;
                        d.is_store = 1'b0;
                        d.state    = ST_MEM;
                    end
                    OP_STORE: begin
                        d.ea       = rf_b;
                        d.sdata    = rf_a;
                        d.is_store = 1'b1;
                        d.state    = ST_MEM;
                    end
                    OP_LIT: begin
                        // q.pc already points one past this instruction
                        d.ea       = q.pc + dec_off;
                        d.dst      = dec_rd;
                        d.is_store = 1'b0;
                        d.state    = ST_MEM;
                    end
                    default: begin
                        d.state = ST_HALT;
                    end
                endcase
            end
            ST_MEM: begin
                mem_addr = q.ea;
                if (q.is_store) begin
                    mem_we  = 1'b1;
                    d.state = ST_FETCH;
                end else begin
                    d.state = ST_WB;
                end
            end
            ST_WB: begin
                rf_we   = 1'b1;
                d.state = ST_FETCH;
            end
            ST_HALT: begin
                d.state = ST_HALT;
            end
            default: begin
                d.state = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state    <= ST_FETCH;
            q.pc       <= '0;
            q.ea       <= '0;
            q.sdata    <= '0;
            q.dst      <= '0;
            q.is_store <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign halt = (q.state == ST_HALT);

endmodule

// File: rtl/ldst_core_chk.sv
module ldst_core_chk
    import ldst_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input state_e            state,
    input logic [DATA_W-1:0] pc,
    input logic              mem_we,
    input logic              halt
);

    // R2: the PC moves only out of the fetch cycle
    p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FETCH) |=> $stable(pc));

    // R9: one write strobe cycle per store
    p_we_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R6: the write cycle directly follows decode
    p_we_from_decode_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(state) == ST_DECODE));

    // R6: write-back directly follows the memory cycle
    p_wb_after_mem_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WB) |-> ($past(state) == ST_MEM));

    // R7: halt is sticky
    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R7: no writes while halted
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        halt |-> !mem_we);

endmodule

bind ldst_core ldst_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .state  (q.state),
    .pc     (q.pc),
    .mem_we (mem_we),
    .halt   (halt)
);

// File: tb/ldst_core_tb.sv
`timescale 1ns/1ps
module ldst_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, halt;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;

    logic [15:0] dmem [bit [15:0]];
    logic [15:0] mref [bit [15:0]];

    always #4 clk = ~clk;

    ldst_core u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .halt(halt)
    );

    // Synchronous single-port word memory
    always @(posedge clk) begin
        if (mem_we) begin
            dmem[mem_addr] = mem_wdata;
            wr_count++;
        end
        mem_rdata <= dmem.exists(mem_addr) ? dmem[mem_addr] : 16'h0000;
    end

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] dget(input bit [15:0] a);
        return dmem.exists(a) ? dmem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] mget(input bit [15:0] a);
        return mref.exists(a) ? mref[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] enc_rr(input logic [5:0] opc, input int a, input int b, input logic [3:0] pad);
        return {opc, 3'(a), 3'(b), pad};
    endfunction

    function automatic logic [15:0] enc_lit(input int rd, input int off);
        return {4'b1110, 3'(rd), 9'(off)};
    endfunction

    function automatic bit is_undef(input logic [15:0] w);
        return !(w[15:10] == 6'b110000 || w[15:10] == 6'b110001 || w[15:12] == 4'b1110);
    endfunction

    // Reference interpreter over mref, built from the requirements
    task automatic model_run(output int cyc, output int nwr, output bit halted);
        logic [15:0] r [8];
        logic [15:0] pc, w, a;
        for (int i = 0; i < 8; i++) r[i] = 16'h0;
        pc = 16'h0; cyc = 2; nwr = 0; halted = 1'b0;
        for (int s = 0; s < 2000; s++) begin
            w  = mget(pc);
            pc = pc + 16'd1;
            if (w[15:10] == 6'b110000) begin
                a = r[w[9:7]];
                r[w[6:4]] = mget(a);
                cyc += 4;
            end else if (w[15:10] == 6'b110001) begin
                mref[r[w[6:4]]] = r[w[9:7]];
                nwr++;
                cyc += 3;
            end else if (w[15:12] == 4'b1110) begin
                a = pc + {{7{w[8]}}, w[8:0]};
                r[w[11:9]] = mget(a);
                cyc += 4;
            end else begin
                halted = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_case(input string tag, output int cyc_out);
        int exp_cyc, exp_wr, cyc, wr_at_halt;
        bit exp_halt;
        mref = dmem;
        model_run(exp_cyc, exp_wr, exp_halt);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(halt == 1'b0, {tag, " R1 halt"}, 32'(halt), 0);
        check(mem_we == 1'b0, {tag, " R1 we"}, 32'(mem_we), 0);
        check(mem_addr == 16'h0, {tag, " R1 addr"}, 32'(mem_addr), 0);
        wr_count = 0;
        rst = 1'b0;
        cyc = 0;
        while (!halt && cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        cyc_out = cyc;
        check(halt == exp_halt, {tag, " R7 halt reached"}, 32'(halt), 32'(exp_halt));
        check(cyc == exp_cyc, {tag, " R6 cycles"}, 32'(cyc), 32'(exp_cyc));
        check(wr_count == exp_wr, {tag, " R9 write count"}, 32'(wr_count), 32'(exp_wr));
        // R2 R3 R4 R5 R8: final memory image
        foreach (mref[k]) check(dget(k) == mref[k], {tag, " R3 R4 R5 mem"}, {k, dget(k)}, {k, mref[k]});
        foreach (dmem[k]) if (!mref.exists(k)) check(1'b0, {tag, " R2 stray write"}, 32'(k), 0);
        wr_at_halt = wr_count;
        repeat (12) @(negedge clk);
        check(halt == 1'b1, {tag, " R7 halt sticky"}, 32'(halt), 1);
        check(wr_count == wr_at_halt, {tag, " R7 no write halted"}, 32'(wr_count), 32'(wr_at_halt));
    endtask

    initial begin
        int cyc;
        logic [15:0] w;
        void'($urandom(32'd20240611));

        // Directed: literal address, store through it, load back, store copy
        dmem.delete();
        dmem[16'h0000] = enc_lit(1, 15);                        // r1 <- [0x10]
        dmem[16'h0001] = enc_lit(2, 15);                        // r2 <- [0x11]
        dmem[16'h0002] = enc_rr(6'b110001, 2, 1, 4'hA);         // [r1] <- r2
        dmem[16'h0003] = enc_rr(6'b110000, 1, 3, 4'h5);         // r3 <- [r1]
        dmem[16'h0004] = enc_lit(4, 13);                        // r4 <- [0x12]
        dmem[16'h0005] = enc_rr(6'b110001, 3, 4, 4'hF);         // [r4] <- r3
        dmem[16'h0006] = 16'hFFFF;
        dmem[16'h0010] = 16'h0200;
        dmem[16'h0011] = 16'hBEEF;
        dmem[16'h0012] = 16'h0201;
        run_case("dir1", cyc);
        check(dget(16'h0200) == 16'hBEEF, "R4 store via literal address", dget(16'h0200), 16'hBEEF);
        check(dget(16'h0201) == 16'hBEEF, "R3 loaded value stored back", dget(16'h0201), 16'hBEEF);
        check(cyc == 24, "R6 directed cycle total", cyc, 24);

        // Directed: offset extremes, wrap below zero, offset reaching own word
        dmem.delete();
        dmem[16'h0000] = enc_lit(1, -256);                      // addr 0xFF01
        dmem[16'h0001] = enc_lit(2, 255);                       // addr 0x0101
        dmem[16'h0002] = enc_rr(6'b110001, 2, 1, 4'h0);         // [r1] <- r2
        dmem[16'h0003] = enc_lit(5, -4);                        // addr 0x0000
        dmem[16'h0004] = enc_rr(6'b110001, 5, 2, 4'h3);         // [r2] <- r5
        dmem[16'h0005] = 16'h0000;                              // undefined
        dmem[16'hFF01] = 16'h0300;
        dmem[16'h0101] = 16'h1234;
        run_case("dir2", cyc);
        check(dget(16'h0300) == 16'h1234, "R8 negative offset wraps", dget(16'h0300), 16'h1234);
        check(dget(16'h1234) == enc_lit(1, -256), "R5 offset back to own word",
              dget(16'h1234), enc_lit(1, -256));
        check(cyc == 4 + 4 + 3 + 4 + 3 + 2, "R6 second directed cycles", cyc, 20);

        // Directed: first word undefined (opcode 111111)
        dmem.delete();
        dmem[16'h0000] = 16'hFC00;
        run_case("dir3", cyc);
        check(cyc == 2, "R7 immediate halt", cyc, 2);

        // Random programs
        for (int p = 0; p < 8; p++) begin
            dmem.delete();
            for (int s = 0; s < 32; s++) begin
                dmem[16'h0080 + 16'(s)] = 16'h0100 + 16'($urandom_range(0, 31));
                dmem[16'h0100 + 16'(s)] = ($urandom_range(0, 1) == 1) ?
                    (16'h0100 + 16'($urandom_range(0, 31))) : 16'($urandom);
            end
            for (int pc = 0; pc < 28; pc++) begin
                case ($urandom_range(0, 2))
                    0: w = enc_lit($urandom_range(0, 7), 16'h0080 + $urandom_range(0, 31) - (pc + 1));
                    1: w = enc_rr(6'b110000, $urandom_range(0, 7), $urandom_range(0, 7), 4'($urandom));
                    default: w = enc_rr(6'b110001, $urandom_range(0, 7), $urandom_range(0, 7), 4'($urandom));
                endcase
                dmem[16'(pc)] = w;
            end
            do w = 16'($urandom); while (!is_undef(w));
            dmem[16'd28] = w;
            run_case($sformatf("rnd%0d", p), cyc);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule